// File: doc/BRIEF.md
# Prefix-Matching Differential Prefetcher

This block learns the shape of repeating task instances. A task instance is described by a vector of per-position address differentials. Each differential is the signed distance between the address this instance touches at a position and the address the previous instance touched at the same position. When an instance ends with a full vector, the block keeps that vector in a small fully associative table. Slots are replaced in round-robin order.

While a new instance runs, its differentials arrive one element at a time. The block narrows the set of stored vectors that share the prefix seen so far. While two or more stored vectors remain candidates, it makes no prediction. At the element where exactly one candidate is left, it predicts every remaining position of that vector at once. For each remaining position it forms the previous instance's address plus the stored differential. These addresses leave the block one per cycle on a valid/ready stream, where a cache fill engine can pick them up.

Top module: `dpf_prefetcher`

## Requirements
- R1: After reset the table holds no vectors and `pf_valid` is low.
- R2: A vector is stored on `task_stop` only if exactly VEC_LEN differential elements were accepted since the matching `task_start`. An instance that ended with fewer elements leaves the table unchanged.
- R3: Stored vectors go into slots in round-robin order. With ENTRIES slots, each new vector after the table is full replaces the oldest one.
- R4: While the current prefix matches two or more stored vectors (duplicates count separately), no prefetch address is produced.
- R5: When element k (counted from 0) leaves exactly one matching stored vector and k < VEC_LEN-1, `pf_valid` is high in the cycle after that element. The block then presents positions k+1 to VEC_LEN-1 of that vector in ascending order.
- R6: The address for position p is slot p of `prev_addrs` (bits p*ADDR_W upward) plus the stored two's-complement differential for p, sign-extended and wrapped modulo 2^ADDR_W.
- R7: One address is transferred per cycle in which `pf_valid` and `pf_ready` are both high. While `pf_ready` is low, `pf_valid` stays high and `pf_addr` stays unchanged.
- R8: If the prefix matches no stored vector, no prefetch is made for the rest of that instance.
- R9: If the prefix first becomes unique at the last element (k = VEC_LEN-1), nothing is emitted.
- R10: `task_start` clears the prefix-match state and abandons any stream still pending. `pf_valid` is low in the following cycle.
- R11: A differential offered in the same cycle as `task_start` or `task_stop`, or outside an instance, is not taken into the vector.
- R12: At most one prediction is made per instance. Later elements, whether or not they agree, neither cancel it nor start another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_start | input | 1 | One-cycle strobe: a new task instance begins |
| task_stop | input | 1 | One-cycle strobe: the running instance ends |
| diff_valid | input | 1 | A differential element is offered this cycle |
| diff_elem | input | DIFF_W | Two's-complement differential for the next position |
| prev_addrs | input | VEC_LEN*ADDR_W | Previous instance's address per position, held for the instance |
| pf_valid | output | 1 | A prefetch address is offered |
| pf_ready | input | 1 | Consumer takes the offered address |
| pf_addr | output | ADDR_W | Prefetch address |

## Verification
The element that makes the prefix unique is registered once. The first prefetch address is therefore visible one cycle after that element, and each later address appears one cycle after the previous handshake. A vector committed on `task_stop` takes part in matching from the next `task_start` onward. `pf_valid` falls one cycle after `task_start`. The bench drives inputs on the falling edge and samples 1 ns later, so it observes every result in exactly the cycle these latencies predict. Stream contents are collected on each handshake and compared after the instance has drained.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
  typedef enum logic [1:0] {
    PFX_IDLE,
    PFX_SEARCH,
    PFX_LOCKED,
    PFX_MISS
  } pfx_state_e;
endpackage

// File: rtl/dpf_vec_table.sv
module dpf_vec_table #(
  parameter int ENTRIES = 4,
  parameter int VEC_LEN = 4,
  parameter int DIFF_W  = 16,
  localparam int SEL_W  = $clog2(ENTRIES)
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       wr_en,
  input  logic [VEC_LEN-1:0][DIFF_W-1:0]             wr_vec,
  output logic [ENTRIES-1:0][VEC_LEN-1:0][DIFF_W-1:0] tbl_diff,
  output logic [ENTRIES-1:0]                         tbl_valid,
  output logic [ENTRIES-1:0]                         tbl_valid_nxt
);
  logic [SEL_W-1:0] rr_slot;

  always_comb begin
    tbl_valid_nxt = tbl_valid;
    if (wr_en) tbl_valid_nxt[rr_slot] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_valid <= '0;
      tbl_diff  <= '0;
      rr_slot   <= '0;
    end else if (wr_en) begin
      tbl_diff[rr_slot] <= wr_vec;
      tbl_valid         <= tbl_valid_nxt;
      rr_slot           <= (rr_slot == SEL_W'(ENTRIES - 1)) ? '0 : rr_slot + 1'b1;
    end
  end
endmodule

// File: rtl/dpf_prefix_match.sv
module dpf_prefix_match
  import dpf_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int VEC_LEN = 4,
  parameter int DIFF_W  = 16,
  localparam int SEL_W  = $clog2(ENTRIES),
  localparam int POS_W  = $clog2(VEC_LEN),
  localparam int IDX_W  = $clog2(VEC_LEN + 1)
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       task_start,
  input  logic                                       task_stop,
  input  logic                                       diff_valid,
  input  logic [DIFF_W-1:0]                          diff_elem,
  input  logic [ENTRIES-1:0][VEC_LEN-1:0][DIFF_W-1:0] tbl_diff,
  input  logic [ENTRIES-1:0]                         tbl_valid_nxt,
  output logic                                       fire,
  output logic [SEL_W-1:0]                           fire_sel,
  output logic [POS_W-1:0]                           fire_pos,
  output logic                                       commit_en,
  output logic [VEC_LEN-1:0][DIFF_W-1:0]             commit_vec
);
  pfx_state_e           state;
  logic [IDX_W-1:0]     idx;
  logic [POS_W-1:0]     idx_lo;
  logic [ENTRIES-1:0]   cand;
  logic [ENTRIES-1:0]   hit;
  logic                 accept;

  function automatic int count_set(input logic [ENTRIES-1:0] v);
    int n = 0;
    for (int i = 0; i < ENTRIES; i++) n += int'(v[i]);
    return n;
  endfunction

  assign idx_lo    = idx[POS_W-1:0];
  assign accept    = diff_valid && !task_start && !task_stop &&
                     (state != PFX_IDLE) && (idx < IDX_W'(VEC_LEN));
  assign commit_en = task_stop && (state != PFX_IDLE) && (idx == IDX_W'(VEC_LEN));

  always_comb begin
    for (int e = 0; e < ENTRIES; e++)
      hit[e] = cand[e] && (tbl_diff[e][idx_lo] == diff_elem);
  end

  always_comb begin
    fire_sel = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (hit[e]) fire_sel = SEL_W'(e);
  end

  assign fire     = accept && (state == PFX_SEARCH) && (count_set(hit) == 1) &&
                    (idx < IDX_W'(VEC_LEN - 1));
  assign fire_pos = POS_W'(idx + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PFX_IDLE;
      idx        <= '0;
      cand       <= '0;
      commit_vec <= '0;
    end else if (task_start) begin
      state <= PFX_SEARCH;
      idx   <= '0;
      cand  <= tbl_valid_nxt;
    end else if (task_stop) begin
      state <= PFX_IDLE;
    end else if (accept) begin
      commit_vec[idx_lo] <= diff_elem;
      idx                <= idx + 1'b1;
      cand               <= hit;
      if (state == PFX_SEARCH) begin
        if (hit == '0) state <= PFX_MISS;
        else if (fire)  state <= PFX_LOCKED;
      end
    end
  end
endmodule

// File: rtl/dpf_suffix_emit.sv
module dpf_suffix_emit #(
  parameter int VEC_LEN = 4,
  parameter int DIFF_W  = 16,
  parameter int ADDR_W  = 32,
  localparam int POS_W  = $clog2(VEC_LEN)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           task_start,
  input  logic                           fire,
  input  logic [POS_W-1:0]               fire_pos,
  input  logic [VEC_LEN-1:0][DIFF_W-1:0] fire_vec,
  input  logic [VEC_LEN*ADDR_W-1:0]      prev_addrs,
  input  logic                           pf_ready,
  output logic                           pf_valid,
  output logic [ADDR_W-1:0]              pf_addr
);
  logic                           busy;
  logic [POS_W-1:0]               pos;
  logic [VEC_LEN-1:0][DIFF_W-1:0] vec;

  function automatic logic [ADDR_W-1:0] target(input logic [ADDR_W-1:0] base,
                                               input logic [DIFF_W-1:0] d);
    return base + {{(ADDR_W - DIFF_W){d[DIFF_W-1]}}, d};
  endfunction

  assign pf_valid = busy;
  assign pf_addr  = target(prev_addrs[pos*ADDR_W +: ADDR_W], vec[pos]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pos  <= '0;
      vec  <= '0;
    end else if (task_start) begin
      busy <= 1'b0;
    end else if (fire) begin
      busy <= 1'b1;
      pos  <= fire_pos;
      vec  <= fire_vec;
    end else if (busy && pf_ready) begin
      if (pos == POS_W'(VEC_LEN - 1)) busy <= 1'b0;
      else                            pos  <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/dpf_prefetcher.sv
module dpf_prefetcher #(
  parameter int ENTRIES = 4,
  parameter int VEC_LEN = 4,
  parameter int DIFF_W  = 16,
  parameter int ADDR_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      task_start,
  input  logic                      task_stop,
  input  logic                      diff_valid,
  input  logic [DIFF_W-1:0]         diff_elem,
  input  logic [VEC_LEN*ADDR_W-1:0] prev_addrs,
  output logic                      pf_valid,
  input  logic                      pf_ready,
  output logic [ADDR_W-1:0]         pf_addr
);
  localparam int SEL_W = $clog2(ENTRIES);
  localparam int POS_W = $clog2(VEC_LEN);

  logic [ENTRIES-1:0][VEC_LEN-1:0][DIFF_W-1:0] tbl_diff;
  logic [ENTRIES-1:0]                          tbl_valid;
  logic [ENTRIES-1:0]                          tbl_valid_nxt;
  logic                                        commit_en;
  logic [VEC_LEN-1:0][DIFF_W-1:0]              commit_vec;
  logic                                        fire;
  logic [SEL_W-1:0]                            fire_sel;
  logic [POS_W-1:0]                            fire_pos;

  dpf_vec_table #(.ENTRIES(ENTRIES), .VEC_LEN(VEC_LEN), .DIFF_W(DIFF_W)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(commit_en), .wr_vec(commit_vec),
    .tbl_diff(tbl_diff), .tbl_valid(tbl_valid), .tbl_valid_nxt(tbl_valid_nxt)
  );

  dpf_prefix_match #(.ENTRIES(ENTRIES), .VEC_LEN(VEC_LEN), .DIFF_W(DIFF_W)) u_match (
    .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_stop(task_stop),
    .diff_valid(diff_valid), .diff_elem(diff_elem), .tbl_diff(tbl_diff),
    .tbl_valid_nxt(tbl_valid_nxt), .fire(fire), .fire_sel(fire_sel),
    .fire_pos(fire_pos), .commit_en(commit_en), .commit_vec(commit_vec)
  );

  dpf_suffix_emit #(.VEC_LEN(VEC_LEN), .DIFF_W(DIFF_W), .ADDR_W(ADDR_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .task_start(task_start), .fire(fire),
    .fire_pos(fire_pos), .fire_vec(tbl_diff[fire_sel]), .prev_addrs(prev_addrs),
    .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );
endmodule

// File: rtl/dpf_checks.sv
module dpf_checks #(
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               task_start,
  input logic               task_stop,
  input logic               pf_valid,
  input logic               pf_ready,
  input logic               fire,
  input logic [ENTRIES-1:0] tbl_valid
);
  // R5: a unique prefix launches the stream on the next cycle
  assert_fire_launches_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pf_valid);

  // R12: only one prediction per instance, so the emitter is idle when one fires
  assert_single_shot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !pf_valid);

  // R7: an offered address is not withdrawn while the consumer stalls
  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready && !task_start |=> pf_valid);

  // R10: a new instance drops any pending stream
  assert_start_aborts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    task_start |=> !pf_valid);

  // R2: the table only changes when an instance ends
  assert_store_on_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !task_stop |=> $stable(tbl_valid));
endmodule

bind dpf_prefetcher dpf_checks #(.ENTRIES(ENTRIES)) u_checks (
  .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_stop(task_stop),
  .pf_valid(pf_valid), .pf_ready(pf_ready), .fire(fire), .tbl_valid(tbl_valid)
);

// File: tb/dpf_prefetcher_bench.sv
`timescale 1ns/1ps
module dpf_prefetcher_bench;
  localparam int NROW = 12;
  localparam logic [31:0] PREV [4] = '{32'h1000_0000, 32'h2000_0000, 32'h0000_0010, 32'hFFFF_FFF0};

  // Each row is one full instance; ROW_FIRST is the first predicted position (4 = none)
  localparam logic [15:0] ROW_D [NROW][4] = '{
    '{16'd32, 16'd96, 16'd8, 16'd64},
    '{16'd32, 16'd96, 16'd8, 16'd64},
    '{16'd32, 16'd96, 16'd8, 16'd64},
    '{16'd32, 16'd100, 16'hFFFB, 16'd7},
    '{16'd32, 16'd100, 16'hFFFB, 16'd7},
    '{16'd32, 16'd96, 16'd8, 16'hFFFF},
    '{16'd32, 16'd96, 16'd8, 16'hFFFF},
    '{16'hFFF9, 16'hFFEC, 16'd16, 16'h7FFF},
    '{16'hFFF9, 16'hFFEC, 16'd16, 16'h7FFF},
    '{16'd32, 16'd100, 16'hFFFB, 16'd7},
    '{16'd32, 16'd100, 16'hFFFB, 16'd7},
    '{16'd1000, 16'd3, 16'hFFFD, 16'd1}
  };
  localparam int ROW_FIRST [NROW] = '{4, 1, 4, 8'd4, 2, 4, 4, 4, 1, 4, 2, 4};
  localparam string ROW_TAG [NROW] = '{"R8", "R5", "R4", "R8", "R3", "R4", "R9", "R8", "R6", "R3", "R5", "R8"};

  logic        clk = 0;
  logic        rst_n = 0;
  logic        task_start = 0, task_stop = 0, diff_valid = 0, pf_ready = 1;
  logic [15:0] diff_elem = '0;
  logic [127:0] prev_addrs;
  logic        pf_valid;
  logic [31:0] pf_addr;

  int n_chk = 0, n_bad = 0, ncap = 0;
  logic [31:0] cap [64];
  bit reported = 0;

  assign prev_addrs = {PREV[3], PREV[2], PREV[1], PREV[0]};
  always #2 clk = ~clk;

  dpf_prefetcher u_dpf_prefetcher (
    .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_stop(task_stop),
    .diff_valid(diff_valid), .diff_elem(diff_elem), .prev_addrs(prev_addrs),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  always @(negedge clk) begin
    #1;
    if (rst_n && pf_valid && pf_ready) begin
      cap[ncap % 64] = pf_addr;
      ncap++;
    end
  end

  function automatic logic [31:0] want(input int p, input logic [15:0] d);
    return PREV[p] + {{16{d[15]}}, d};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report;
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // all drive tasks are entered at a falling edge and return at one
  task automatic pulse_start;
    task_start = 1; @(negedge clk); task_start = 0;
  endtask
  task automatic pulse_stop;
    task_stop = 1; @(negedge clk); task_stop = 0;
  endtask
  task automatic drive_diff(input logic [15:0] d);
    diff_valid = 1; diff_elem = d; @(negedge clk); diff_valid = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_row(input int r);
    int base, first, got;
    base  = ncap;
    first = ROW_FIRST[r];
    pulse_start;
    for (int k = 0; k < 4; k++) drive_diff(ROW_D[r][k]);
    pulse_stop;
    idle(8);
    got = ncap - base;
    check(got == 4 - first, ROW_TAG[r], 32'(got), 32'(4 - first));
    for (int p = first; p < 4; p++)
      check(cap[(base + p - first) % 64] == want(p, ROW_D[r][p]), "R6",
            cap[(base + p - first) % 64], want(p, ROW_D[r][p]));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    report;
  end

  initial begin
    int base;
    idle(3);
    rst_n = 1;
    idle(2);
    #1 check(pf_valid == 0, "R1", 32'(pf_valid), 32'd0);

    for (int r = 0; r < NROW; r++) do_row(r);

    // R5/R7: table now holds a single vector starting with 1000
    @(negedge clk);
    pf_ready = 0;
    pulse_start;
    #1 check(pf_valid == 0, "R5", 32'(pf_valid), 32'd0);
    @(negedge clk);
    drive_diff(16'd1000);
    #1 check(pf_valid == 1, "R5", 32'(pf_valid), 32'd1);
    check(pf_addr == 32'h2000_0003, "R6", pf_addr, 32'h2000_0003);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #1 check(pf_valid == 1 && pf_addr == 32'h2000_0003, "R7", pf_addr, 32'h2000_0003);
    end
    @(negedge clk);
    base = ncap;
    pf_ready = 1;
    idle(3);
    #2 check(pf_valid == 0 && ncap - base == 3, "R7", 32'(ncap - base), 32'd3);
    check(cap[base % 64] == 32'h2000_0003, "R7", cap[base % 64], 32'h2000_0003);
    check(cap[(base + 1) % 64] == 32'h0000_000D, "R7", cap[(base + 1) % 64], 32'h0000_000D);
    check(cap[(base + 2) % 64] == 32'hFFFF_FFF1, "R7", cap[(base + 2) % 64], 32'hFFFF_FFF1);
    @(negedge clk);
    pulse_stop;

    // R10: restart while a stalled stream is pending
    pf_ready = 0;
    pulse_start;
    drive_diff(16'd1000);
    #1 check(pf_valid == 1, "R10", 32'(pf_valid), 32'd1);
    @(negedge clk);
    pulse_start;
    #1 check(pf_valid == 0, "R10", 32'(pf_valid), 32'd0);
    @(negedge clk);
    base = ncap;
    pf_ready = 1;
    idle(5);
    check(ncap - base == 0, "R10", 32'(ncap - base), 32'd0);
    pulse_stop;

    // R2: short instance is not kept
    pulse_start;
    drive_diff(16'd500); drive_diff(16'd1); drive_diff(16'd2);
    pulse_stop;
    drive_diff(16'd3);
    idle(2);

    // R11: diffs in the start and stop cycles are not taken
    base = ncap;
    diff_valid = 1; diff_elem = 16'd777;
    pulse_start;
    diff_valid = 0;
    drive_diff(16'd500);
    idle(3);
    check(ncap - base == 0, "R2", 32'(ncap - base), 32'd0);
    drive_diff(16'd1); drive_diff(16'd2); drive_diff(16'd3);
    diff_valid = 1; diff_elem = 16'd55;
    pulse_stop;
    diff_valid = 0;
    idle(2);

    // R12: prediction fires on 500 and later mismatches leave it intact
    base = ncap;
    pulse_start;
    drive_diff(16'd500); drive_diff(16'd9); drive_diff(16'd9); drive_diff(16'd9);
    pulse_stop;
    idle(6);
    check(ncap - base == 3, "R12", 32'(ncap - base), 32'd3);
    check(cap[base % 64] == want(1, 16'd1), "R11", cap[base % 64], want(1, 16'd1));
    check(cap[(base + 1) % 64] == want(2, 16'd2), "R12", cap[(base + 1) % 64], want(2, 16'd2));
    check(cap[(base + 2) % 64] == want(3, 16'd3), "R12", cap[(base + 2) % 64], want(3, 16'd3));

    report;
  end
endmodule